// File: doc/BRIEF.md
# Compare-Interrupt Down-Counting Timer

This block is a 32-bit down-counter that software controls through five word registers on a small register bus. A two-bit source field chooses one of three single-cycle tick-enable inputs, or none. A 12-bit prescaler then divides the chosen tick. Each prescaled tick lowers the count by one. When the count passes zero it either restarts from a programmable load value or wraps to all ones, as the control register selects.

A compare register is watched on every step. When the counter steps onto the compare value, a sticky flag is set. That flag drives a level interrupt, but only while both the timer enable and the compare-interrupt enable are on. Software clears the flag by writing a one to status bit 0.

Software can also:
- write the load value straight into the counter,
- restart the count when the timer is enabled,
- issue a soft reset that keeps the enable-type control bits.

Top module: `cdt_timer`

## Requirements
- R1: Word offsets map as 0 control, 1 status, 2 load, 3 compare, 4 count. A read request returns its data on `bus_rdata` in the cycle after the request. Offsets 5 and above read as zero, and writes to them change nothing.
- R2: Control bits are: 0 enable, 1 enable-mode, 2 compare-interrupt enable, 3 reload, 15:4 prescale, 16 soft reset (self-clearing), 17 immediate overwrite, 21:18 low-power enables (storage only), 25:24 clock source. Bits 31:26 and bit 16 always read as zero.
- R3: Clock source 00 never advances the counter. Sources 01, 10 and 11 take ticks from `tick_i[0]`, `tick_i[1]` and `tick_i[2]`.
- R4: With prescale value P, the counter steps once every P+1 selected ticks. The first step comes on the (P+1)th tick after the prescaler was idle.
- R5: A step from zero loads the load value when reload is 1, and loads 0xFFFFFFFF when reload is 0. Any other step decrements by one.
- R6: A load-register write with immediate overwrite set also writes the counter in the same cycle. Without that bit, the counter is untouched.
- R7: A control write that takes enable from 0 to 1 with enable-mode set starts the counter from the load value if reload is set, else from 0xFFFFFFFF.
- R8: A step whose new count equals the compare value sets status bit 0. The bit stays set until acknowledged. A set in the same cycle as an acknowledge wins.
- R9: Writing status with bit 0 = 1 clears the flag. Writing bit 0 = 0 has no effect.
- R10: `irq_o` is high exactly when the flag, the compare-interrupt enable and the enable are all 1.
- R11: A control write with bit 16 set stores only bits 0, 1 and 21:18 of the written value. It clears status, compare and the prescaler, and sets load to 0xFFFFFFFF. It clears the count, unless the same write starts the counter per R7.
- R12: Hard reset sets control, status, compare and count to 0 and load to 0xFFFFFFFF. Clearing enable freezes the count and keeps every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| tick_i | input | 3 | Tick-enable inputs, one cycle per tick |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_o | output | 1 | Level compare interrupt |

## Verification
Register writes, counter steps and the compare flag all take effect at the clock edge that samples the request or tick, so `irq_o` and the counter are up to date one edge after the stimulus. Read data is one edge later than the register contents it samples. The bench drives inputs on the falling edge and compares on the next falling edge. It checks every cycle against a reference model, advanced at each rising edge, that holds the pre-edge state for reads. Directed tick bursts count the exact number of rising edges with a tick high, so prescaler phase and wrap points are known in advance.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int DATA_W = 32;
    localparam int PSC_W  = 12;
    localparam int SRC_W  = 2;
    localparam int N_SRC  = (1 << SRC_W) - 1;

    localparam int SWR_BIT = 16;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h03FE_FFFF;
    localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h003C_0003;
    localparam logic [DATA_W-1:0] CNT_MAX    = '1;

    typedef struct packed {
        logic [5:0]       rsvd_hi;
        logic [SRC_W-1:0] clk_src;
        logic [1:0]       rsvd_mid;
        logic [3:0]       lp_en;
        logic             ovw;
        logic             swr;
        logic [PSC_W-1:0] psc;
        logic             rld;
        logic             cie;
        logic             enmod;
        logic             en;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_LOAD  = 3'd2,
        SEL_CMP   = 3'd3,
        SEL_COUNT = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            32'd0:   return SEL_CTRL;
            32'd1:   return SEL_STAT;
            32'd2:   return SEL_LOAD;
            32'd3:   return SEL_CMP;
            32'd4:   return SEL_COUNT;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_from_write(input logic [DATA_W-1:0] wd);
        if (wd[SWR_BIT])
            return ctrl_t'(wd & CTRL_KEEP);
        return ctrl_t'(wd & CTRL_WMASK);
    endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale #(
    parameter int PSC_W = 12,
    parameter int SRC_W = 2,
    localparam int N_SRC = (1 << SRC_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [SRC_W-1:0] src,
    input  logic [PSC_W-1:0] psc,
    input  logic [N_SRC-1:0] tick_i,
    output logic             step
);

    logic [N_SRC-1:0] tick_hit;
    logic             tick_sel;
    logic             active;
    logic             at_lim;
    logic [PSC_W-1:0] pre_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        assign tick_hit[g] = tick_i[g] && (src == SRC_W'(g + 1));
    end

    assign tick_sel = |tick_hit;
    assign active   = en && (src != '0);
    assign at_lim   = (pre_q >= psc);
    assign step     = active && tick_sel && at_lim;

    always_ff @(posedge clk) begin
        if (rst || clr || !active) begin
            pre_q <= '0;
        end else if (tick_sel) begin
            pre_q <= at_lim ? '0 : pre_q + 1'b1;
        end
    end

    AST_STEP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        step |=> (pre_q == '0)); // R4

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (src == '0) |-> !step); // R3

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] cnt,
    output logic         hit
);

    logic [W-1:0] nxt;

    always_comb begin
        if (cnt == '0)
            nxt = reload ? load_val : '1;
        else
            nxt = cnt - 1'b1;
    end

    assign hit = step && !wr && (nxt == cmp_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (wr)
            cnt <= wr_val;
        else if (step)
            cnt <= nxt;
    end

    AST_WRAP_MAX: assert property (@(posedge clk) disable iff (rst)
        (step && !wr && cnt == '0 && !reload) |=> (cnt == '1)); // R5

    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (step && !wr && cnt == '0 && reload) |=> (cnt == $past(load_val))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step && !wr) |=> $stable(cnt)); // R12

endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt,
    input  logic              hit,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] cmp_q,
    output logic              cnt_wr,
    output logic [DATA_W-1:0] cnt_wr_val,
    output logic              swr,
    output logic [DATA_W-1:0] rdata_q,
    output logic              irq
);

    reg_sel_e          sel;
    ctrl_t             ctrl_new;
    logic              flag_q;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp, rd_req;
    logic              start;
    logic [DATA_W-1:0] load_eff;
    logic [DATA_W-1:0] rd_mux;

    assign sel      = decode_offset(32'(bus_addr));
    assign wr_ctrl  = bus_valid && bus_write && (sel == SEL_CTRL);
    assign wr_stat  = bus_valid && bus_write && (sel == SEL_STAT);
    assign wr_load  = bus_valid && bus_write && (sel == SEL_LOAD);
    assign wr_cmp   = bus_valid && bus_write && (sel == SEL_CMP);
    assign rd_req   = bus_valid && !bus_write;

    assign ctrl_new = ctrl_from_write(bus_wdata);
    assign swr      = wr_ctrl && bus_wdata[SWR_BIT];
    assign load_eff = swr ? CNT_MAX : load_q;
    assign start    = wr_ctrl && ctrl_new.en && !ctrl_q.en && ctrl_new.enmod;

    always_comb begin
        cnt_wr     = 1'b0;
        cnt_wr_val = '0;
        if (start) begin
            cnt_wr     = 1'b1;
            cnt_wr_val = ctrl_new.rld ? load_eff : CNT_MAX;
        end else if (swr) begin
            cnt_wr     = 1'b1;
            cnt_wr_val = '0;
        end else if (wr_load && ctrl_q.ovw) begin
            cnt_wr     = 1'b1;
            cnt_wr_val = bus_wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CTRL:  rd_mux = ctrl_q;
            SEL_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, flag_q};
            SEL_LOAD:  rd_mux = load_q;
            SEL_CMP:   rd_mux = cmp_q;
            SEL_COUNT: rd_mux = cnt;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            load_q  <= CNT_MAX;
            cmp_q   <= '0;
            flag_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_new;
            if (swr) begin
                load_q <= CNT_MAX;
                cmp_q  <= '0;
            end
            if (wr_load)
                load_q <= bus_wdata;
            if (wr_cmp)
                cmp_q <= bus_wdata;
            if (swr)
                flag_q <= 1'b0;
            else if (hit)
                flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[0])
                flag_q <= 1'b0;
            if (rd_req)
                rdata_q <= rd_mux;
        end
    end

    assign irq = flag_q && ctrl_q.cie && ctrl_q.en;

    AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        swr |=> (!flag_q && cmp_q == '0 && load_q == CNT_MAX)); // R11

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[0] && !hit) |=> !flag_q); // R9

    AST_HIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q); // R8

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sel == SEL_CTRL) |=> (rdata_q[31:26] == '0 && !rdata_q[SWR_BIT])); // R2

    AST_BAD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sel == SEL_NONE) |=> (rdata_q == '0)); // R1

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  tick_i,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] load_q, cmp_q, cnt, cnt_wr_val;
    logic              cnt_wr, swr, step, hit;

    cdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt        (cnt),
        .hit        (hit),
        .ctrl_q     (ctrl_q),
        .load_q     (load_q),
        .cmp_q      (cmp_q),
        .cnt_wr     (cnt_wr),
        .cnt_wr_val (cnt_wr_val),
        .swr        (swr),
        .rdata_q    (bus_rdata),
        .irq        (irq_o)
    );

    cdt_prescale #(.PSC_W(PSC_W), .SRC_W(SRC_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (swr),
        .en     (ctrl_q.en),
        .src    (ctrl_q.clk_src),
        .psc    (ctrl_q.psc),
        .tick_i (tick_i),
        .step   (step)
    );

    cdt_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .reload   (ctrl_q.rld),
        .load_val (load_q),
        .cmp_val  (cmp_q),
        .wr       (cnt_wr),
        .wr_val   (cnt_wr_val),
        .cnt      (cnt),
        .hit      (hit)
    );

endmodule

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  tick_i = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cdt_timer u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Reference model, advanced at each rising edge from the requirements
    logic [31:0] m_ctrl, m_load, m_cmp, m_cnt, m_rd, m_nc, m_nxt, m_leff;
    logic [11:0] m_pre;
    logic        m_flag, m_tick, m_step, m_hit, m_swr, m_cw;
    logic [31:0] m_cwv;

    function automatic logic [31:0] ctrl_expect(input logic [31:0] wd);
        return wd[16] ? (wd & 32'h003C_0003) : (wd & 32'h03FE_FFFF);
    endfunction

    function automatic logic model_irq(input logic f, input logic [31:0] c);
        return f && c[2] && c[0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_load = 32'hFFFF_FFFF; m_cmp = 0; m_cnt = 0;
            m_flag = 0; m_pre = 0; m_rd = 0;
        end else begin
            if (bus_valid && !bus_write) begin
                case (bus_addr)
                    3'd0: m_rd = m_ctrl;
                    3'd1: m_rd = {31'b0, m_flag};
                    3'd2: m_rd = m_load;
                    3'd3: m_rd = m_cmp;
                    3'd4: m_rd = m_cnt;
                    default: m_rd = 0;
                endcase
            end
            m_tick = (m_ctrl[25:24] == 0) ? 1'b0 : tick_i[m_ctrl[25:24] - 2'd1];
            m_step = m_ctrl[0] && m_tick && (m_pre >= m_ctrl[15:4]);
            m_nxt  = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
            m_swr  = bus_valid && bus_write && bus_addr == 0 && bus_wdata[16];
            m_nc   = ctrl_expect(bus_wdata);
            m_leff = m_swr ? 32'hFFFF_FFFF : m_load;
            m_cw = 0; m_cwv = 0;
            if (bus_valid && bus_write && bus_addr == 0 && m_nc[0] && !m_ctrl[0] && m_nc[1]) begin
                m_cw = 1; m_cwv = m_nc[3] ? m_leff : 32'hFFFF_FFFF;
            end else if (m_swr) begin
                m_cw = 1; m_cwv = 0;
            end else if (bus_valid && bus_write && bus_addr == 2 && m_ctrl[17]) begin
                m_cw = 1; m_cwv = bus_wdata;
            end
            m_hit = m_step && !m_cw && (m_nxt == m_cmp);
            if (m_swr) m_flag = 0;
            else if (m_hit) m_flag = 1;
            else if (bus_valid && bus_write && bus_addr == 1 && bus_wdata[0]) m_flag = 0;
            if (m_swr || !m_ctrl[0] || m_ctrl[25:24] == 0) m_pre = 0;
            else if (m_tick) m_pre = m_step ? 12'd0 : m_pre + 1;
            if (m_cw) m_cnt = m_cwv;
            else if (m_step) m_cnt = m_nxt;
            if (m_swr) begin m_load = 32'hFFFF_FFFF; m_cmp = 0; end
            if (bus_valid && bus_write && bus_addr == 2) m_load = bus_wdata;
            if (bus_valid && bus_write && bus_addr == 3) m_cmp = bus_wdata;
            if (bus_valid && bus_write && bus_addr == 0) m_ctrl = m_nc;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse(input logic [2:0] m, input int n);
        @(negedge clk);
        tick_i = m;
        repeat (n) @(negedge clk);
        tick_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic        pend;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;

        // R12 hard reset values
        rd_check("R12", 0, 0);
        rd_check("R12", 1, 0);
        rd_check("R12", 2, 32'hFFFF_FFFF);
        rd_check("R12", 3, 0);
        rd_check("R12", 4, 0);
        check("R12", irq_o, 0);

        // R1 unmapped offsets
        bus_wr(5, 32'h1234_5678);
        rd_check("R1", 5, 0);
        rd_check("R1", 7, 0);
        rd_check("R1", 0, 0);
        bus_wr(3, 32'h55);
        rd_check("R1", 3, 32'h55);

        // R2 control masking, R7 start from load
        bus_wr(0, 32'hFFFE_FFFF);
        rd_check("R2", 0, 32'h03FE_FFFF);
        rd_check("R7", 4, 32'hFFFF_FFFF);
        bus_wr(0, 0);

        // R11 soft reset
        bus_wr(2, 32'h10);
        bus_wr(3, 5);
        bus_wr(0, 32'h013C_000F);
        rd_check("R7", 4, 32'h10);
        bus_wr(0, 32'h013D_000F);
        rd_check("R11", 0, 32'h003C_0003);
        rd_check("R11", 1, 0);
        rd_check("R11", 2, 32'hFFFF_FFFF);
        rd_check("R11", 3, 0);
        rd_check("R11", 4, 0);
        bus_wr(0, 0);

        // R6 immediate overwrite
        bus_wr(0, 32'h0002_0000);
        bus_wr(2, 32'h20);
        rd_check("R6", 4, 32'h20);
        bus_wr(0, 0);
        bus_wr(2, 32'h30);
        rd_check("R6", 4, 32'h20);
        rd_check("R6", 2, 32'h30);

        // R4 prescale /3, R5 reload, R3 source select
        bus_wr(0, 32'h0002_0000);
        bus_wr(2, 3);
        bus_wr(0, 32'h0100_0029);
        pulse(3'b001, 3);
        rd_check("R4", 4, 2);
        pulse(3'b001, 2);
        rd_check("R4", 4, 2);
        pulse(3'b001, 1);
        rd_check("R4", 4, 1);
        pulse(3'b001, 6);
        rd_check("R5", 4, 3);
        pulse(3'b010, 6);
        rd_check("R3", 4, 3);
        bus_wr(0, 32'h0200_0029);
        pulse(3'b010, 3);
        rd_check("R3", 4, 2);
        bus_wr(0, 32'h0000_0029);
        pulse(3'b111, 6);
        rd_check("R3", 4, 2);

        // R5 rollover to max
        bus_wr(0, 32'h0100_0001);
        pulse(3'b001, 3);
        rd_check("R5", 4, 32'hFFFF_FFFF);

        // R12 disable holds, R7 restart both ways
        bus_wr(0, 0);
        pulse(3'b111, 4);
        rd_check("R12", 4, 32'hFFFF_FFFF);
        bus_wr(0, 32'h0100_000B);
        rd_check("R7", 4, 3);
        bus_wr(0, 0);
        bus_wr(0, 32'h0100_0003);
        rd_check("R7", 4, 32'hFFFF_FFFF);
        bus_wr(0, 0);

        // R8 compare flag, R9 ack, R10 irq gating
        bus_wr(0, 32'h0002_0000);
        bus_wr(2, 5);
        bus_wr(3, 3);
        bus_wr(0, 32'h0100_0009);
        pulse(3'b001, 2);
        rd_check("R8", 1, 1);
        check("R10", irq_o, 0);
        bus_wr(0, 32'h0100_000D);
        check("R10", irq_o, 1);
        bus_wr(1, 0);
        rd_check("R9", 1, 1);
        bus_wr(1, 1);
        rd_check("R9", 1, 0);
        check("R9", irq_o, 0);
        pulse(3'b001, 6);
        rd_check("R8", 1, 1);
        check("R10", irq_o, 1);
        bus_wr(0, 32'h0100_000C);
        check("R10", irq_o, 0);
        rd_check("R8", 1, 1);

        // Random phase against the reference model
        pend = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (pend) begin
                case (bus_addr)
                    3'd0: check("R2", bus_rdata, m_rd);
                    3'd1: check("R8", bus_rdata, m_rd);
                    3'd2: check("R6", bus_rdata, m_rd);
                    3'd4: check("R5", bus_rdata, m_rd);
                    default: check("R1", bus_rdata, m_rd);
                endcase
            end
            check("R10", irq_o, model_irq(m_flag, m_ctrl));
            pend = 0;
            bus_valid = 0; bus_write = 0;
            tick_i = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 9) < 3) begin
                bus_valid = 1;
                bus_write = $urandom_range(0, 1) == 1;
                bus_addr  = 3'($urandom_range(0, 7));
                w = $urandom();
                case (bus_addr)
                    3'd0: begin
                        w[15:4] = 12'($urandom_range(0, 3));
                        w[16]   = ($urandom_range(0, 15) == 0);
                        w[3]    = ($urandom_range(0, 3) != 0);
                        w[0]    = ($urandom_range(0, 4) != 0);
                    end
                    3'd2, 3'd3: w = $urandom_range(0, 20);
                    default: ;
                endcase
                bus_wdata = w;
                pend = !bus_write;
            end
        end
        @(negedge clk);
        bus_valid = 0; tick_i = 0;

        // R12 hard reset after activity
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd_check("R12", 0, 0);
        rd_check("R12", 2, 32'hFFFF_FFFF);
        rd_check("R12", 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule